// File: doc/BRIEF.md
# Translation Buffer Pointer Generator

This block forms the memory address of the translation storage buffer slot that software-managed miss handling should read after a translation miss. A strobe captures the faulting tag-access value together with two register sets, one for context zero and one for every nonzero context. From these the block produces two 64-bit pointers, one per page-size class, in the cycle after the strobe.

Each pointer begins with the upper base field of the selected buffer register. The size code from that register sets how many tag-access bits become the index. The page-size code from the matching configuration register sets how far the tag-access value is shifted before indexing, in steps of three bits. A buffer can be split in two halves, one per page-size class. In that case the pointer for the second class carries one extra address bit just above its index field. Fetching the entry and comparing its tag are the job of the logic around this block.

Top module: `tsb_ptr_gen`

## Requirements
- R1: While rst_n is low, and after it rises until the first start, ptr_ps0, ptr_ps1 and done are all zero.
- R2: done is high in exactly those cycles that directly follow a clock edge at which start was high. Back-to-back starts give back-to-back done cycles.
- R3: At a clock edge with start low, ptr_ps0 and ptr_ps1 keep their values, whatever the other inputs do.
- R4: The context field is tag_access[12:0]. When it is zero, c0_base and c0_cfg are used. Otherwise cx_base and cx_cfg are used. Tag bits above 12 never affect this choice.
- R5: Bits 63:13 of the selected base register appear in both pointers at the same positions. Base bits 11:4 have no effect on either pointer.
- R6: With size code S = base[3:0] and page code P, each pointer ORs in bits (12+S) down to 4 of tag_access shifted right by 9+3*P. Pointer bits below 4 take nothing from the tag.
- R7: P for ptr_ps0 is cfg[2:0]. P for ptr_ps1 is cfg[10:8]. Other cfg bits have no effect.
- R8: When the split flag base[12] is set, bit 13+S of ptr_ps1 is forced to one. The split flag never changes ptr_ps0.
- R9: Bits 3:0 of both pointers are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe; pointers update at this edge |
| tag_access | input | 64 | Faulting virtual page and context (bits 12:0) |
| c0_base | input | 64 | Buffer base register for context zero |
| c0_cfg | input | 64 | Page-size configuration for context zero |
| cx_base | input | 64 | Buffer base register for nonzero contexts |
| cx_cfg | input | 64 | Page-size configuration for nonzero contexts |
| ptr_ps0 | output | 64 | Pointer for page-size class 0 |
| ptr_ps1 | output | 64 | Pointer for page-size class 1 |
| done | output | 1 | One-cycle pulse per start |

## Verification
The bench drives size codes 0 and 15 and page codes 0 and 7. These are the points where a mask that is one bit too narrow or too wide loses or gains the top index bit, or where a wrong shift multiplier draws from the wrong tag bits. It uses context values of one, of only the top context bit set, and of zero with tag bits 13 and up set. A selector that decodes the wrong field would then pick the wrong register set. The split flag is set with distinct class configurations, which exposes a split bit placed at the wrong position or leaking into the class-0 pointer. Noisy base low bits and changing inputs without start expose a base mask that lets junk through and pointers that fail to hold.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int ADDR_W    = 64;
  localparam int CTX_W     = 13;
  localparam int BASE_LSB  = 13;
  localparam int SPLIT_BIT = 12;
  localparam int SIZE_W    = 4;
  localparam int PS_W      = 3;
  localparam int IDX_LSB   = 4;
  localparam int SHIFT_LO  = 9;
  localparam int PS_STEP   = 3;
  localparam int PS1_LSB   = 8;
  localparam int NUM_CLASS = 2;
  localparam int SHAMT_W   = 6;

  typedef logic [ADDR_W-1:0] addr_t;

  // upper base field, everything at or below the split flag cleared
  function automatic addr_t base_part(input addr_t base);
    addr_t keep;
    keep = ~((addr_t'(1) << BASE_LSB) - addr_t'(1));
    return base & keep;
  endfunction

  // tag slice selected by page code and sized by the buffer size code
  function automatic addr_t index_part(input addr_t tag,
                                       input logic [SIZE_W-1:0] sz,
                                       input logic [PS_W-1:0] ps);
    logic [SHAMT_W-1:0] shamt;
    logic [SHAMT_W-1:0] top;
    addr_t upper;
    addr_t lower;
    shamt = SHAMT_W'(SHIFT_LO) + SHAMT_W'(PS_STEP) * SHAMT_W'(ps);
    top   = SHAMT_W'(BASE_LSB) + SHAMT_W'(sz);
    upper = (addr_t'(1) << top) - addr_t'(1);
    lower = (addr_t'(1) << IDX_LSB) - addr_t'(1);
    return (tag >> shamt) & upper & ~lower;
  endfunction

  function automatic addr_t split_part(input logic [SIZE_W-1:0] sz);
    return addr_t'(1) << (SHAMT_W'(BASE_LSB) + SHAMT_W'(sz));
  endfunction
endpackage

// File: rtl/tsb_ctx_mux.sv
module tsb_ctx_mux
  import tsb_pkg::*;
(
  input  addr_t tag_access,
  input  addr_t c0_base,
  input  addr_t c0_cfg,
  input  addr_t cx_base,
  input  addr_t cx_cfg,
  output logic  ctx_is_zero,
  output addr_t sel_base,
  output addr_t sel_cfg
);
  assign ctx_is_zero = (tag_access[CTX_W-1:0] == '0);
  assign sel_base    = ctx_is_zero ? c0_base : cx_base;
  assign sel_cfg     = ctx_is_zero ? c0_cfg  : cx_cfg;
endmodule

// File: rtl/tsb_index_calc.sv
module tsb_index_calc
  import tsb_pkg::*;
#(
  parameter int CLASS_ID = 0
) (
  input  addr_t tag_access,
  input  addr_t base,
  input  addr_t cfg,
  output addr_t ptr
);
  localparam int PS_LSB = (CLASS_ID == 0) ? 0 : PS1_LSB;

  logic [SIZE_W-1:0] size_code;
  logic [PS_W-1:0]   page_code;
  logic              split_on;
  addr_t             extra;

  assign size_code = base[SIZE_W-1:0];
  assign page_code = cfg[PS_LSB +: PS_W];

  generate
    if (CLASS_ID == 0) begin : g_no_split
      assign split_on = 1'b0;
    end else begin : g_split
      assign split_on = base[SPLIT_BIT];
    end
  endgenerate

  assign extra = split_on ? split_part(size_code) : '0;
  assign ptr   = base_part(base) | extra | index_part(tag_access, size_code, page_code);
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] tag_access,
  input  logic [ADDR_W-1:0] c0_base,
  input  logic [ADDR_W-1:0] c0_cfg,
  input  logic [ADDR_W-1:0] cx_base,
  input  logic [ADDR_W-1:0] cx_cfg,
  output logic [ADDR_W-1:0] ptr_ps0,
  output logic [ADDR_W-1:0] ptr_ps1,
  output logic              done
);
  localparam int AGREE_LSB = BASE_LSB + (1 << SIZE_W);

  logic  ctx_is_zero;
  addr_t sel_base;
  addr_t sel_cfg;
  addr_t calc_ptr [NUM_CLASS];
  addr_t ptr_q    [NUM_CLASS];
  logic  done_q;
  logic  split_q;

  tsb_ctx_mux u_ctx (
    .tag_access (tag_access),
    .c0_base    (c0_base),
    .c0_cfg     (c0_cfg),
    .cx_base    (cx_base),
    .cx_cfg     (cx_cfg),
    .ctx_is_zero(ctx_is_zero),
    .sel_base   (sel_base),
    .sel_cfg    (sel_cfg)
  );

  generate
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
      tsb_index_calc #(.CLASS_ID(c)) u_calc (
        .tag_access(tag_access),
        .base      (sel_base),
        .cfg       (sel_cfg),
        .ptr       (calc_ptr[c])
      );
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr_q[c] <= '0;
        else if (start) ptr_q[c] <= calc_ptr[c];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      split_q <= 1'b0;
    end else begin
      done_q <= start;
      if (start) split_q <= sel_base[SPLIT_BIT];
    end
  end

  assign ptr_ps0 = ptr_q[0];
  assign ptr_ps1 = ptr_q[1];
  assign done    = done_q;

  assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(start));

  assert_hold_without_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(ptr_ps0) && $stable(ptr_ps1)));

  assert_low_nibble_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_ps0[IDX_LSB-1:0] == '0) && (ptr_ps1[IDX_LSB-1:0] == '0));

  assert_unsplit_upper_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !split_q) |-> (ptr_ps0[ADDR_W-1:AGREE_LSB] == ptr_ps1[ADDR_W-1:AGREE_LSB]));
endmodule

// File: tb/tsb_ptr_gen_bench.sv
`timescale 1ns/1ps
module tsb_ptr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] tag_access = '0, c0_base = '0, c0_cfg = '0, cx_base = '0, cx_cfg = '0;
  logic [63:0] ptr_ps0, ptr_ps1;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  logic [63:0] exp0 = '0, exp1 = '0;
  logic exp_done = 1'b0;

  always #2.5 clk = ~clk;

  tsb_ptr_gen u_tsb_ptr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .tag_access(tag_access),
    .c0_base(c0_base), .c0_cfg(c0_cfg), .cx_base(cx_base), .cx_cfg(cx_cfg),
    .ptr_ps0(ptr_ps0), .ptr_ps1(ptr_ps1), .done(done)
  );

  // bit-by-bit reference of the pointer rules
  function automatic logic [63:0] model_ptr(input logic [63:0] tag, input logic [63:0] base,
                                            input logic [63:0] cfg, input int cls);
    logic [63:0] r;
    int sz, ps, sh;
    sz = int'(base[3:0]);
    ps = (cls == 0) ? int'(cfg[2:0]) : int'(cfg[10:8]);
    sh = 9 + 3 * ps;
    r = '0;
    for (int b = 13; b < 64; b++) r[b] = base[b];
    for (int b = 4; b <= 12 + sz; b++) if (tag[b + sh]) r[b] = 1'b1;
    if (cls == 1 && base[12]) r[13 + sz] = 1'b1;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp0 <= '0; exp1 <= '0; exp_done <= 1'b0;
    end else begin
      exp_done <= start;
      if (start) begin
        if (tag_access[12:0] == 13'd0) begin
          exp0 <= model_ptr(tag_access, c0_base, c0_cfg, 0);
          exp1 <= model_ptr(tag_access, c0_base, c0_cfg, 1);
        end else begin
          exp0 <= model_ptr(tag_access, cx_base, cx_cfg, 0);
          exp1 <= model_ptr(tag_access, cx_base, cx_cfg, 1);
        end
      end
    end
  end

  task automatic check_now();
    checks++;
    if (done !== exp_done) begin
      failures++;
      $display("FAIL R2 done actual=%0b expected=%0b", done, exp_done);
    end
    checks++;
    if (ptr_ps0 !== exp0) begin
      failures++;
      $display("FAIL %s ptr_ps0 actual=%h expected=%h", cur_req, ptr_ps0, exp0);
    end
    checks++;
    if (ptr_ps1 !== exp1) begin
      failures++;
      $display("FAIL %s ptr_ps1 actual=%h expected=%h", cur_req, ptr_ps1, exp1);
    end
    checks++;
    if (ptr_ps0[3:0] !== 4'd0 || ptr_ps1[3:0] !== 4'd0) begin
      failures++;
      $display("FAIL R9 low nibble actual=%h/%h expected=0", ptr_ps0[3:0], ptr_ps1[3:0]);
    end
  endtask

  // one cycle: check at negedge, then drive next inputs
  task automatic step(input logic s, input logic [63:0] t, input logic [63:0] b0,
                      input logic [63:0] f0, input logic [63:0] bx, input logic [63:0] fx);
    @(negedge clk);
    check_now();
    start = s; tag_access = t; c0_base = b0; c0_cfg = f0; cx_base = bx; cx_cfg = fx;
  endtask

  task automatic idle();
    step(1'b0, tag_access, c0_base, c0_cfg, cx_base, cx_cfg);
  endtask

  initial begin
    // R1 reset state
    cur_req = "R1";
    repeat (3) begin @(negedge clk); check_now(); end
    rst_n = 1'b1;
    idle(); idle();

    // R4 context select
    cur_req = "R4";
    step(1, 64'hFFFF_0000_0000_0000, 64'hAAAA_0000_0000_2003, 64'h0000_0000_0000_0201,
            64'h5555_0000_0000_4005, 64'h0000_0000_0000_0502);
    step(1, 64'h1234_5678_9ABC_E001, c0_base, c0_cfg, cx_base, cx_cfg);
    step(1, 64'h0F0F_F0F0_1111_1000, c0_base, c0_cfg, cx_base, cx_cfg);
    step(0, 64'h0F0F_F0F0_1111_2000, c0_base, c0_cfg, cx_base, cx_cfg);
    idle();

    // R5 base low-bit noise ignored
    cur_req = "R5";
    step(1, 64'h0000_0000_0000_0000, 64'hDEAD_BEEF_0000_0FF0, 64'h0, 64'h0, 64'h0);
    idle();

    // R6 size code extremes
    cur_req = "R6";
    step(1, 64'hFFFF_FFFF_FFFF_E000, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0);
    step(1, 64'hFFFF_FFFF_FFFF_E000, 64'h8000_0000_0000_000F, 64'h0, 64'h0, 64'h0);
    step(1, 64'h0000_0000_1000_0000, 64'h0000_0000_0000_000F, 64'h0, 64'h0, 64'h0);
    idle();

    // R7 page codes, distinct per class, other cfg bits noisy
    cur_req = "R7";
    step(1, 64'h0123_4567_89AB_C000, 64'h0000_0000_0000_000F, 64'hFFFF_FFFF_FFFF_F8F8, 64'h0, 64'h0);
    step(1, 64'h0123_4567_89AB_C000, 64'h0000_0000_0000_000F, 64'h0000_0000_0000_0007, 64'h0, 64'h0);
    step(1, 64'hFFFF_FFFF_FFFF_C000, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0703, 64'h0, 64'h0);
    idle();

    // R8 split flag
    cur_req = "R8";
    step(1, 64'h0, 64'h0000_0000_0000_100F, 64'h0, 64'h0, 64'h0);
    step(1, 64'h0, 64'h0000_0000_0000_1000, 64'h0, 64'h0, 64'h0);
    step(1, 64'h0, 64'h0, 64'h0, 64'h0000_0000_0000_1005, 64'h0000_0000_0000_0402);
    step(1, 64'h3333_3333_3333_3003, c0_base, c0_cfg, cx_base, cx_cfg);
    idle();

    // R3 hold with changing inputs and no start
    cur_req = "R3";
    for (int i = 0; i < 8; i++)
      step(0, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, {$urandom, $urandom});
    idle();

    // R2 mixed random traffic, including back-to-back starts
    cur_req = "R2 R6";
    for (int i = 0; i < 300; i++) begin
      logic [63:0] t;
      t = {$urandom, $urandom};
      if (i % 4 == 0) t[12:0] = '0;
      step(logic'($urandom_range(0, 1)), t, {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, {$urandom, $urandom});
    end
    idle(); idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule